// File: doc/BRIEF.md
# Write-Through Store Buffer

This block sits between a write-through data cache and the external data bus. When the processor issues a store, the block records its address, write data and byte-select mask in a small queue and acknowledges it in the same cycle. The processor then carries on without waiting for the slower external write. In the background, a drain sequencer sends the queued stores to the bus one at a time, oldest first. Each store goes out as its own write transaction.

Loads keep memory ordering strict. A load that arrives while stores are still queued waits until the queue is completely empty. It then passes straight through to the bus, and the bus response is returned to the processor. A bus error on a drained store is dropped, because that store was already acknowledged. A bus error on a load is reported to the processor. The queue depth is a power of two, set by its base-2 logarithm.

Top module: `wt_store_buffer`

## Requirements
- R1: A store request (`cpu_req`=1, `cpu_we`=1) that arrives while fewer than 2**SB_LOG stores are queued gets `cpu_ack`=1 in the same cycle, whatever the bus is doing.
- R2: Whenever the queue is not empty, the bus drives a write (`bus_req`=1, `bus_we`=1) carrying the address, data and byte-select of the oldest queued store. Stores reach the bus in the order they were acknowledged, each as a separate transaction.
- R3: Only one bus transaction is outstanding at a time. A drain write holds its address, data and select stable until `bus_ack` or `bus_err` is seen. Only then is the entry removed from the queue.
- R4: The queue holds exactly 2**SB_LOG stores. While it is full, a store request gets no `cpu_ack` until a drain has completed in an earlier cycle.
- R5: A load request (`cpu_req`=1, `cpu_we`=0) is neither issued as a bus read nor acknowledged while any store is queued. Once the queue is empty, the load is driven onto the bus with `bus_we`=0 and its own address. `cpu_ack` then follows `bus_ack`, and `cpu_rdata` carries `bus_rdata`.
- R6: `bus_err` on a drain write never raises `cpu_err`. The entry is still removed, and the next store is drained. `bus_err` on a load raises `cpu_err` in the same cycle and ends the load.
- R7: During and after reset the queue is empty. With no load request present, `bus_req` is 0, and with no request present, `cpu_ack` is 0.
- R8: A store accepted in the same cycle that a drain write completes takes effect together with the removal. Neither is lost, and the drained order is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_sel | input | SEL_W | Byte-select mask |
| cpu_ack | output | 1 | Request completed |
| cpu_err | output | 1 | Load ended in a bus error |
| cpu_rdata | output | DATA_W | Load data |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | Bus write enable |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_sel | output | SEL_W | Bus byte-select mask |
| bus_ack | input | 1 | Bus transaction completed |
| bus_err | input | 1 | Bus transaction ended in error |
| bus_rdata | input | DATA_W | Bus read data |

## Verification
The critical collision is a processor store being accepted at the tail of the queue in the same cycle that a drain write completes at the head. To provoke it, the bench issues stores back to back while the bus model acknowledges after one wait cycle, so pushes and pops keep landing on the same edge. A bus-error address is also planted among these stores, so an error-terminated pop coincides with an acceptance as well. A behavioural queue, advanced on every clock, judges the outcome. It predicts the acknowledge and the exact head presented on the bus each cycle, so a lost push, a double pop or a reordering shows up as a mismatch.

// File: rtl/sb_pkg.sv
package sb_pkg;

   typedef enum logic [1:0] {
      OWN_IDLE  = 2'd0,
      OWN_DRAIN = 2'd1,
      OWN_LOAD  = 2'd2
   } bus_owner_e;

   function automatic int sb_ptr_bits(input int log2_depth);
      return log2_depth + 1;
   endfunction

endpackage

// File: rtl/sb_fifo.sv
module sb_fifo #(
   parameter int SB_LOG   = 2,
   parameter int SB_DEPTH = 4,
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int SEL_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [DATA_W-1:0] push_data,
   input  logic [SEL_W-1:0]  push_sel,
   input  logic              pop,
   output logic [ADDR_W-1:0] head_addr,
   output logic [DATA_W-1:0] head_data,
   output logic [SEL_W-1:0]  head_sel,
   output logic              empty,
   output logic              full
);
   localparam int PW = sb_pkg::sb_ptr_bits(SB_LOG);

   logic [PW-1:0]     wr_q, rd_q;
   logic [SB_LOG-1:0] wr_idx, rd_idx;
   logic [ADDR_W-1:0] ent_addr [SB_DEPTH];
   logic [DATA_W-1:0] ent_data [SB_DEPTH];
   logic [SEL_W-1:0]  ent_sel  [SB_DEPTH];

   assign wr_idx = wr_q[SB_LOG-1:0];
   assign rd_idx = rd_q[SB_LOG-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= '0;
         rd_q <= '0;
      end else begin
         if (push) wr_q <= wr_q + PW'(1);
         if (pop)  rd_q <= rd_q + PW'(1);
      end
   end

   for (genvar i = 0; i < SB_DEPTH; i++) begin : g_ent
      logic [ADDR_W-1:0] a_q;
      logic [DATA_W-1:0] d_q;
      logic [SEL_W-1:0]  s_q;
      always_ff @(posedge clk) begin
         if (push && (wr_idx == SB_LOG'(i))) begin
            a_q <= push_addr;
            d_q <= push_data;
            s_q <= push_sel;
         end
      end
      assign ent_addr[i] = a_q;
      assign ent_data[i] = d_q;
      assign ent_sel[i]  = s_q;
   end

   assign head_addr = ent_addr[rd_idx];
   assign head_data = ent_data[rd_idx];
   assign head_sel  = ent_sel[rd_idx];

   assign empty = (wr_q == rd_q);
   assign full  = (wr_q[SB_LOG] != rd_q[SB_LOG]) && (wr_idx == rd_idx);

endmodule

// File: rtl/sb_bus_ctrl.sv
module sb_bus_ctrl
   import sb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int SEL_W  = 4
) (
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [SEL_W-1:0]  cpu_sel,
   output logic              cpu_ack,
   output logic              cpu_err,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              q_empty,
   input  logic              q_full,
   input  logic [ADDR_W-1:0] head_addr,
   input  logic [DATA_W-1:0] head_data,
   input  logic [SEL_W-1:0]  head_sel,
   output logic              q_push,
   output logic              q_pop,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [SEL_W-1:0]  bus_sel,
   input  logic              bus_ack,
   input  logic              bus_err,
   input  logic [DATA_W-1:0] bus_rdata
);
   bus_owner_e owner;
   logic       store_in, load_in, done;

   assign store_in = cpu_req && cpu_we;
   assign load_in  = cpu_req && !cpu_we;
   assign done     = bus_ack || bus_err;

   always_comb begin
      if (!q_empty)     owner = OWN_DRAIN;
      else if (load_in) owner = OWN_LOAD;
      else              owner = OWN_IDLE;
   end

   assign q_push = store_in && !q_full;

   always_comb begin
      bus_req   = 1'b0;
      bus_we    = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      bus_sel   = '0;
      q_pop     = 1'b0;
      cpu_ack   = q_push;
      cpu_err   = 1'b0;
      unique case (owner)
         OWN_DRAIN: begin
            bus_req   = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = head_addr;
            bus_wdata = head_data;
            bus_sel   = head_sel;
            q_pop     = done;
         end
         OWN_LOAD: begin
            bus_req   = 1'b1;
            bus_addr  = cpu_addr;
            bus_sel   = cpu_sel;
            cpu_ack   = bus_ack;
            cpu_err   = bus_err;
         end
         default: ;
      endcase
   end

   assign cpu_rdata = bus_rdata;

   logic unused_wdata;
   assign unused_wdata = ^cpu_wdata;

endmodule

// File: rtl/wt_store_buffer.sv
module wt_store_buffer #(
   parameter int SB_LOG   = 2,
   parameter int SB_DEPTH = 4,
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int SEL_W    = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [SEL_W-1:0]  cpu_sel,
   output logic              cpu_ack,
   output logic              cpu_err,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [SEL_W-1:0]  bus_sel,
   input  logic              bus_ack,
   input  logic              bus_err,
   input  logic [DATA_W-1:0] bus_rdata
);
   if (SB_LOG < 1) begin : g_bad_log
      $error("SB_LOG must be at least 1");
   end
   if (SB_DEPTH != (1 << SB_LOG)) begin : g_bad_depth
      $error("SB_DEPTH must equal 2**SB_LOG");
   end
   if (SEL_W * 8 != DATA_W) begin : g_bad_sel
      $error("SEL_W must be DATA_W/8");
   end

   logic              q_push, q_pop, q_empty, q_full;
   logic [ADDR_W-1:0] head_addr;
   logic [DATA_W-1:0] head_data;
   logic [SEL_W-1:0]  head_sel;

   sb_fifo #(
      .SB_LOG(SB_LOG), .SB_DEPTH(SB_DEPTH),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
   ) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(q_push), .push_addr(cpu_addr), .push_data(cpu_wdata),
      .push_sel(cpu_sel), .pop(q_pop),
      .head_addr(head_addr), .head_data(head_data), .head_sel(head_sel),
      .empty(q_empty), .full(q_full)
   );

   sb_bus_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
   ) u_ctrl (
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_sel(cpu_sel),
      .cpu_ack(cpu_ack), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
      .q_empty(q_empty), .q_full(q_full),
      .head_addr(head_addr), .head_data(head_data), .head_sel(head_sel),
      .q_push(q_push), .q_pop(q_pop),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_sel(bus_sel),
      .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
   );

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
   parameter int SB_DEPTH = 4,
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int SEL_W    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic              cpu_ack,
   input logic              cpu_err,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [SEL_W-1:0]  bus_sel,
   input logic              bus_ack,
   input logic              bus_err
);
   int  occ;
   logic st_in, drain_done;

   assign st_in      = cpu_req && cpu_we && cpu_ack;
   assign drain_done = bus_req && bus_we && (bus_ack || bus_err);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= 0;
      else        occ <= occ + (st_in ? 1 : 0) - (drain_done ? 1 : 0);
   end

   AST_STORE_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && occ < SB_DEPTH) |-> cpu_ack); // R1

   AST_DRAIN_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (occ != 0) |-> (bus_req && bus_we)); // R2

   AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && !bus_ack && !bus_err) |=>
      (bus_req && bus_we && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_sel))); // R3

   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == SB_DEPTH && cpu_req && cpu_we) |-> !cpu_ack); // R4

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (occ >= 0 && occ <= SB_DEPTH)); // R4

   AST_LOAD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we && occ != 0) |-> (!cpu_ack && !(bus_req && !bus_we))); // R5

   AST_STORE_ERR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we) |-> !cpu_err); // R6

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == 0 && !(cpu_req && !cpu_we)) |-> !bus_req); // R7

endmodule

bind wt_store_buffer sb_checker #(
   .SB_DEPTH(SB_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
   .cpu_ack(cpu_ack), .cpu_err(cpu_err), .bus_req(bus_req), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_sel(bus_sel),
   .bus_ack(bus_ack), .bus_err(bus_err)
);

// File: tb/sim_wt_store_buffer.sv
module sim_wt_store_buffer;
   localparam int LOG = 2, DEPTH = 4, AW = 32, DW = 32, SW = 4;
   localparam logic [DW-1:0] RD_KEY = 32'hA5A5_0F0F;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0;
   logic cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [SW-1:0] cpu_sel = '0;
   logic cpu_ack, cpu_err;
   logic [DW-1:0] cpu_rdata;
   logic bus_req, bus_we;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [SW-1:0] bus_sel;
   logic bus_ack = 1'b0, bus_err = 1'b0;
   logic [DW-1:0] bus_rdata = '0;

   wt_store_buffer #(.SB_LOG(LOG), .SB_DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_sel(cpu_sel),
      .cpu_ack(cpu_ack), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_sel(bus_sel), .bus_ack(bus_ack),
      .bus_err(bus_err), .bus_rdata(bus_rdata));

   typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; logic [SW-1:0] s; } st_t;
   st_t q[$];

   int checks = 0, errors = 0;
   int lat = 0, wait_cnt = 0;
   logic [AW-1:0] err_addr = 32'hFFFF_FFFF;
   bit saw_r4 = 0, saw_r6 = 0, saw_r8 = 0;
   bit got_ack, got_err;
   logic p_rst = 1'b0, p_req = 1'b0, p_we = 1'b0;
   logic [AW-1:0] p_addr = '0;
   logic [DW-1:0] p_data = '0;
   logic [SW-1:0] p_sel = '0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      int sz;
      bit ld, st, e_req, e_push, e_pop, e_ack, e_err;
      string tag;
      @(negedge clk);
      rst_n = p_rst; cpu_req = p_req; cpu_we = p_we;
      cpu_addr = p_addr; cpu_wdata = p_data; cpu_sel = p_sel;
      #1;
      bus_ack = 1'b0; bus_err = 1'b0;
      if (bus_req && wait_cnt >= lat) begin
         if (bus_addr == err_addr) bus_err = 1'b1;
         else bus_ack = 1'b1;
      end
      bus_rdata = bus_addr ^ RD_KEY;
      #1;
      sz = q.size();
      ld = cpu_req && !cpu_we;
      st = cpu_req && cpu_we;
      e_req = (sz > 0) || ld;
      chk(bus_req === e_req, (sz > 0) ? "R2 bus_req" : (ld ? "R5 bus_req" : "R7 bus_req"),
          64'(bus_req), 64'(e_req));
      if (sz > 0) begin
         chk(bus_we === 1'b1 && bus_addr === q[0].a, "R2 drain addr/we",
             {31'd0, bus_we, bus_addr}, {32'd1, q[0].a});
         chk(bus_wdata === q[0].d && bus_sel === q[0].s, "R3 drain data/sel",
             {28'd0, bus_sel, bus_wdata}, {28'd0, q[0].s, q[0].d});
      end else if (ld) begin
         chk(bus_we === 1'b0 && bus_addr === cpu_addr, "R5 load addr/we",
             {31'd0, bus_we, bus_addr}, {32'd0, cpu_addr});
      end
      e_push = st && (sz < DEPTH);
      e_pop  = (sz > 0) && (bus_ack || bus_err);
      e_ack  = e_push || (ld && sz == 0 && bus_ack);
      e_err  = ld && sz == 0 && bus_err;
      if (!rst_n) tag = "R7 ack in reset";
      else if (st) tag = (sz < DEPTH) ? (e_pop ? "R8 ack" : "R1 ack") : "R4 ack";
      else tag = ld ? "R5 ack" : "R7 ack";
      chk(cpu_ack === e_ack, tag, 64'(cpu_ack), 64'(e_ack));
      chk(cpu_err === e_err, "R6 cpu_err", 64'(cpu_err), 64'(e_err));
      if (ld && sz == 0 && bus_ack)
         chk(cpu_rdata === (cpu_addr ^ RD_KEY), "R5 rdata", 64'(cpu_rdata), 64'(cpu_addr ^ RD_KEY));
      if (st && sz == DEPTH) saw_r4 = 1;
      if (sz > 0 && bus_err) saw_r6 = 1;
      if (e_push && e_pop) saw_r8 = 1;
      if (bus_req && !(bus_ack || bus_err)) wait_cnt++;
      else wait_cnt = 0;
      if (e_pop) void'(q.pop_front());
      if (e_push) q.push_back('{a: cpu_addr, d: cpu_wdata, s: cpu_sel});
      got_ack = cpu_ack;
      got_err = cpu_err;
   endtask

   task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [SW-1:0] s);
      p_req = 1'b1; p_we = 1'b1; p_addr = a; p_data = d; p_sel = s;
      do step(); while (!got_ack);
      p_req = 1'b0;
   endtask

   task automatic load(input logic [AW-1:0] a);
      p_req = 1'b1; p_we = 1'b0; p_addr = a; p_sel = 4'hF;
      do step(); while (!(got_ack || got_err));
      p_req = 1'b0;
   endtask

   task automatic idle(input int n);
      p_req = 1'b0;
      repeat (n) step();
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL R3 watchdog expired actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      p_rst = 1'b0;
      idle(3);
      chk(bus_req === 1'b0 && cpu_ack === 1'b0, "R7 reset outputs", {bus_req, cpu_ack}, 2'b00);
      p_rst = 1'b1;
      idle(2);
      chk(bus_req === 1'b0, "R7 idle after reset", 64'(bus_req), 0);

      // fast bus, short burst of stores
      lat = 0;
      for (int i = 0; i < 3; i++) store(32'h1000 + 32'(i * 4), 32'hC0DE_0000 + 32'(i), 4'hF);
      idle(6);

      // slow bus: fill, stall, then load waits for drain
      lat = 3;
      for (int i = 0; i < 6; i++) store(32'h2000 + 32'(i * 4), 32'h5500_0000 + 32'(i), 4'(i + 1));
      load(32'h3000);
      idle(4);

      // error on a drained store is swallowed
      lat = 1;
      err_addr = 32'h4004;
      for (int i = 0; i < 3; i++) store(32'h4000 + 32'(i * 4), 32'hEE00_0000 + 32'(i), 4'h3);
      load(32'h4100);
      idle(6);

      // error on a load is reported
      err_addr = 32'h5000;
      load(32'h5000);
      err_addr = 32'hFFFF_FFFF;
      idle(2);

      // back-to-back stores against one-wait bus: push and pop collide
      lat = 1;
      err_addr = 32'h6010;
      for (int i = 0; i < 10; i++) store(32'h6000 + 32'(i * 4), 32'h7700_0000 + 32'(i), 4'(1 << (i % 4)));
      load(32'h6100);
      store(32'h6200, 32'h1234_5678, 4'hC);
      idle(8);

      chk(saw_r4, "R4 full stall seen", 64'(saw_r4), 1);
      chk(saw_r6, "R6 drain error seen", 64'(saw_r6), 1);
      chk(saw_r8, "R8 push/pop collision seen", 64'(saw_r8), 1);
      chk(q.size() == 0 && bus_req === 1'b0, "R2 all drained", 64'(q.size()), 0);
      summary();
      $finish;
   end
endmodule